// File: doc/BRIEF.md
# Virtual Address Region and Permission Checker

This block takes one 32-bit virtual access per cycle and decides what happens to it. Some segments bypass translation, some are closed to user code, and the rest depend on a result from an external translation buffer. The request carries the address, a write flag, the privilege level and three control bits: translation enable, single-virtual mode and a bit that closes the store-queue window to user code. The external lookup is supplied in the same cycle. It gives a two-bit status and, for a hit, the entry's user, writable and dirty flags, its physical page and its page-size mask.

One clock after a request, the block registers either a physical address or exactly one fault code. When the fault comes from translation, it also stores the offending virtual address. A combinational output tells the external lookup whether the address space ID takes part in the match. The block holds no translation entries of its own.

Top module: `vaddr_guard`

## Requirements
- R1: During and after synchronous reset, rsp_valid is 0, rsp_fault is 0 (no fault), rsp_paddr is 0 and fault_vaddr is 0.
- R2: rsp_valid is high exactly in the cycle after a cycle with req_valid high, and the response describes that request.
- R3: A privileged access at or above 0xE0000000 returns the address unchanged. A privileged access in 0x80000000..0xBFFFFFFF returns it with bits 31:29 cleared. In both cases the lookup inputs are ignored.
- R4: A user access with bit 31 set faults with code 1 (read) or code 2 (write). The one exception is 0xE0000000..0xE3FFFFFF with cfg_sq_user_off at 0, which returns the address unchanged.
- R5: With cfg_xlate_en at 0, every access that R3 and R4 do not settle returns its address with bits 31:29 cleared. This includes privileged 0xC0000000..0xDFFFFFFF.
- R6: tlb_cmp_asid is 0 only when req_priv and cfg_single_vs are both 1.
- R7: The status encoding is 0 = hit, 1 = miss, 2 or 3 = multiple hit. A miss on a translated access gives code 3 (read) or 4 (write). A multiple hit gives code 5.
- R8: A read hit by a user access on an entry with tlb_user at 0 gives code 6. Privileged reads ignore tlb_user.
- R9: A write hit needs tlb_wr when privileged, and both tlb_wr and tlb_user when user. Otherwise it gives code 7.
- R10: A write hit that passes R9 on an entry with tlb_dirty at 0 gives code 8.
- R11: A permitted translation returns (tlb_ppage & tlb_mask) | (vaddr & ~tlb_mask). If that value is strictly above 0x1C000000, bits 31:29 are forced to 1.
- R12: fault_vaddr loads the request address only on codes 3 to 8. It holds on address errors and on successful accesses.
- R13: Whenever rsp_fault is nonzero, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access presented this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode |
| cfg_xlate_en | input | 1 | Address translation enabled |
| cfg_single_vs | input | 1 | Single-virtual mode |
| cfg_sq_user_off | input | 1 | Closes the store-queue window to user code |
| tlb_status | input | 2 | Lookup result: 0 hit, 1 miss, 2/3 multiple hit |
| tlb_user | input | 1 | Entry allows user access |
| tlb_wr | input | 1 | Entry is writable |
| tlb_dirty | input | 1 | Entry has been written |
| tlb_ppage | input | 32 | Entry physical page |
| tlb_mask | input | 32 | Entry page-size mask |
| tlb_cmp_asid | output | 1 | Lookup must compare address space ID |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 4 | Fault code, 0 = none |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| fault_vaddr | output | 32 | Last translation-fault virtual address |

## Verification
The bench builds the block with its default parameters. These are a 32-bit address with a three-bit segment field, a store-queue window of 64 MB, and an on-chip boundary of 0x1C000000. With these values every segment edge and the window's upper end can be reached directly. The remap test is placed exactly on the boundary value and just above it. The 4 KB, 64 KB and 1 MB masks show that offset bits pass from the virtual address while page bits come from the entry.

// File: rtl/vag_pkg.sv
package vag_pkg;
  typedef enum logic [3:0] {
    FLT_NONE     = 4'd0,
    FLT_ADDR_RD  = 4'd1,
    FLT_ADDR_WR  = 4'd2,
    FLT_MISS_RD  = 4'd3,
    FLT_MISS_WR  = 4'd4,
    FLT_MULTI    = 4'd5,
    FLT_PROT_RD  = 4'd6,
    FLT_PROT_WR  = 4'd7,
    FLT_FIRST_WR = 4'd8
  } fault_e;

  typedef enum logic [1:0] {
    RGN_PASS_RAW,
    RGN_PASS_CLR,
    RGN_ADDR_ERR,
    RGN_XLATE
  } region_e;

  localparam logic [1:0] LK_HIT  = 2'd0;
  localparam logic [1:0] LK_MISS = 2'd1;
endpackage

// File: rtl/vag_seg_decode.sv
module vag_seg_decode
  import vag_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SEG_BITS     = 3,
  parameter int SQ_SPAN_BITS = 26
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  logic              priv,
  input  logic              xlate_en,
  input  logic              single_vs,
  input  logic              sq_user_off,
  output region_e           region,
  output logic              cmp_asid
);
  localparam int SQ_TAG_W = ADDR_W - SQ_SPAN_BITS;
  localparam logic [SQ_TAG_W-1:0] SQ_TAG =
    {{SEG_BITS{1'b1}}, {(SQ_TAG_W-SEG_BITS){1'b0}}};

  logic [SEG_BITS-1:0] seg;
  logic                in_sq;

  assign seg   = vaddr[ADDR_W-1 -: SEG_BITS];
  assign in_sq = (vaddr[ADDR_W-1 -: SQ_TAG_W] == SQ_TAG);

  always_comb begin
    if (vaddr[ADDR_W-1]) begin
      if (priv) begin
        if (&seg)
          region = RGN_PASS_RAW;
        else if (!vaddr[ADDR_W-2])
          region = RGN_PASS_CLR;
        else
          region = xlate_en ? RGN_XLATE : RGN_PASS_CLR;
      end else begin
        region = (in_sq && !sq_user_off) ? RGN_PASS_RAW : RGN_ADDR_ERR;
      end
    end else begin
      region = xlate_en ? RGN_XLATE : RGN_PASS_CLR;
    end
  end

  assign cmp_asid = !(priv && single_vs);
endmodule

// File: rtl/vag_fault_judge.sv
module vag_fault_judge
  import vag_pkg::*;
(
  input  region_e    region,
  input  logic       write,
  input  logic       priv,
  input  logic [1:0] status,
  input  logic       ent_user,
  input  logic       ent_wr,
  input  logic       ent_dirty,
  output fault_e     fault,
  output logic       xlate_class
);
  logic rd_denied;
  logic wr_denied;

  assign rd_denied = !priv && !ent_user;
  assign wr_denied = priv ? !ent_wr : !(ent_wr && ent_user);

  always_comb begin
    fault = FLT_NONE;
    unique case (region)
      RGN_ADDR_ERR: fault = write ? FLT_ADDR_WR : FLT_ADDR_RD;
      RGN_XLATE: begin
        if (status == LK_MISS)
          fault = write ? FLT_MISS_WR : FLT_MISS_RD;
        else if (status != LK_HIT)
          fault = FLT_MULTI;
        else if (!write && rd_denied)
          fault = FLT_PROT_RD;
        else if (write && wr_denied)
          fault = FLT_PROT_WR;
        else if (write && !ent_dirty)
          fault = FLT_FIRST_WR;
        else
          fault = FLT_NONE;
      end
      default: fault = FLT_NONE;
    endcase
  end

  assign xlate_class = (region == RGN_XLATE) && (fault != FLT_NONE);
endmodule

// File: rtl/vag_addr_compose.sv
module vag_addr_compose
  import vag_pkg::*;
#(
  parameter int              ADDR_W       = 32,
  parameter int              SEG_BITS     = 3,
  parameter logic [ADDR_W-1:0] ONCHIP_BOUND = 32'h1C00_0000
) (
  input  logic [ADDR_W-1:0] vaddr,
  input  region_e           region,
  input  logic [ADDR_W-1:0] ppage,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] paddr
);
  localparam int SEG_LSB = ADDR_W - SEG_BITS;
  localparam logic [ADDR_W-1:0] SEG_FILL =
    {{SEG_BITS{1'b1}}, {SEG_LSB{1'b0}}};

  logic [ADDR_W-1:0] joined;
  logic [ADDR_W-1:0] remapped;

  assign joined   = (ppage & mask) | (vaddr & ~mask);
  assign remapped = (joined > ONCHIP_BOUND) ? (joined | SEG_FILL) : joined;

  always_comb begin
    unique case (region)
      RGN_PASS_RAW: paddr = vaddr;
      RGN_PASS_CLR: paddr = {{SEG_BITS{1'b0}}, vaddr[SEG_LSB-1:0]};
      RGN_XLATE:    paddr = remapped;
      default:      paddr = '0;
    endcase
  end
endmodule

// File: rtl/vaddr_guard.sv
module vaddr_guard
  import vag_pkg::*;
#(
  parameter int              ADDR_W       = 32,
  parameter int              SEG_BITS     = 3,
  parameter int              SQ_SPAN_BITS = 26,
  parameter logic [ADDR_W-1:0] ONCHIP_BOUND = 32'h1C00_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_priv,
  input  logic              cfg_xlate_en,
  input  logic              cfg_single_vs,
  input  logic              cfg_sq_user_off,
  input  logic [1:0]        tlb_status,
  input  logic              tlb_user,
  input  logic              tlb_wr,
  input  logic              tlb_dirty,
  input  logic [ADDR_W-1:0] tlb_ppage,
  input  logic [ADDR_W-1:0] tlb_mask,
  output logic              tlb_cmp_asid,
  output logic              rsp_valid,
  output logic [3:0]        rsp_fault,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] fault_vaddr
);
  region_e           region;
  fault_e            fault;
  logic              xlate_class;
  logic [ADDR_W-1:0] paddr;

  vag_seg_decode #(
    .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .SQ_SPAN_BITS(SQ_SPAN_BITS)
  ) u_seg (
    .vaddr(req_vaddr), .priv(req_priv), .xlate_en(cfg_xlate_en),
    .single_vs(cfg_single_vs), .sq_user_off(cfg_sq_user_off),
    .region(region), .cmp_asid(tlb_cmp_asid)
  );

  vag_fault_judge u_judge (
    .region(region), .write(req_write), .priv(req_priv),
    .status(tlb_status), .ent_user(tlb_user), .ent_wr(tlb_wr),
    .ent_dirty(tlb_dirty), .fault(fault), .xlate_class(xlate_class)
  );

  vag_addr_compose #(
    .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .ONCHIP_BOUND(ONCHIP_BOUND)
  ) u_compose (
    .vaddr(req_vaddr), .region(region), .ppage(tlb_ppage),
    .mask(tlb_mask), .paddr(paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 4'd0;
      rsp_paddr   <= '0;
      fault_vaddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= fault;
        rsp_paddr <= (fault == FLT_NONE) ? paddr : '0;
        if (xlate_class)
          fault_vaddr <= req_vaddr;
      end
    end
  end
endmodule

// File: rtl/vaddr_guard_chk.sv
module vaddr_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              req_write,
  input logic              req_priv,
  input logic              cfg_xlate_en,
  input logic              cfg_sq_user_off,
  input logic [1:0]        tlb_status,
  input logic              tlb_cmp_asid,
  input logic              rsp_valid,
  input logic [3:0]        rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [ADDR_W-1:0] fault_vaddr
);
  logic user_outside;
  assign user_outside = !req_priv && req_vaddr[ADDR_W-1] &&
    !((req_vaddr[ADDR_W-1 -: 6] == 6'b111000) && !cfg_sq_user_off);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R4
  user_addr_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && user_outside) |=>
      (rsp_fault == (req_write ? 4'd2 : 4'd1)));
  // R6
  user_asid_chk: assert property (@(posedge clk) disable iff (rst)
    !req_priv |-> tlb_cmp_asid);
  // R7
  miss_code_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_vaddr[ADDR_W-1] && cfg_xlate_en && tlb_status == 2'd1) |=>
      (rsp_fault == (req_write ? 4'd4 : 4'd3)));
  // R12
  fva_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_vaddr) |-> (rsp_valid && rsp_fault >= 4'd3 && rsp_fault <= 4'd8));
  // R13
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 4'd0) |-> (rsp_paddr == '0));
endmodule

bind vaddr_guard vaddr_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_write(req_write), .req_priv(req_priv), .cfg_xlate_en(cfg_xlate_en),
  .cfg_sq_user_off(cfg_sq_user_off), .tlb_status(tlb_status),
  .tlb_cmp_asid(tlb_cmp_asid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr), .fault_vaddr(fault_vaddr)
);

// File: tb/vaddr_guard_bench.sv
module vaddr_guard_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic        cfg_xlate_en = 1'b0;
  logic        cfg_single_vs = 1'b0;
  logic        cfg_sq_user_off = 1'b0;
  logic [1:0]  tlb_status = 2'd1;
  logic        tlb_user = 1'b0;
  logic        tlb_wr = 1'b0;
  logic        tlb_dirty = 1'b0;
  logic [31:0] tlb_ppage = '0;
  logic [31:0] tlb_mask = '0;
  logic        tlb_cmp_asid;
  logic        rsp_valid;
  logic [3:0]  rsp_fault;
  logic [31:0] rsp_paddr;
  logic [31:0] fault_vaddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  vaddr_guard u_vaddr_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_priv(req_priv), .cfg_xlate_en(cfg_xlate_en),
    .cfg_single_vs(cfg_single_vs), .cfg_sq_user_off(cfg_sq_user_off),
    .tlb_status(tlb_status), .tlb_user(tlb_user), .tlb_wr(tlb_wr),
    .tlb_dirty(tlb_dirty), .tlb_ppage(tlb_ppage), .tlb_mask(tlb_mask),
    .tlb_cmp_asid(tlb_cmp_asid), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr), .fault_vaddr(fault_vaddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] va, input logic wr, input logic pv,
                       input logic xe, input logic sqo, input logic [1:0] st,
                       input logic fu, input logic fw, input logic fd,
                       input logic [31:0] pp, input logic [31:0] mk);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_priv = pv; cfg_xlate_en = xe;
    cfg_sq_user_off = sqo; tlb_status = st; tlb_user = fu; tlb_wr = fw;
    tlb_dirty = fd; tlb_ppage = pp; tlb_mask = mk; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [3:0] code, input logic [31:0] pa);
    chk(req, {31'd0, rsp_valid}, 32'd1);
    chk(req, {28'd0, rsp_fault}, {28'd0, code});
    chk(req, rsp_paddr, pa);
  endtask

  task automatic t_reset;
    chk("R1", {31'd0, rsp_valid}, 32'd0);
    chk("R1", {28'd0, rsp_fault}, 32'd0);
    chk("R1", rsp_paddr, 32'd0);
    chk("R1", fault_vaddr, 32'd0);
  endtask

  task automatic t_priv_pass;
    apply(32'hFFFF_0010, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R3", 4'd0, 32'hFFFF_0010);
    apply(32'hA123_4567, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R3", 4'd0, 32'h0123_4567);
    apply(32'hB000_0004, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R3", 4'd0, 32'h1000_0004);
    @(negedge clk);
    chk("R2", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_user_segments;
    apply(32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1, 1, 1, 32'h0, 32'h0);
    expect_rsp("R4", 4'd1, 32'h0);
    apply(32'hC000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1, 1, 1, 32'h0, 32'h0);
    expect_rsp("R4", 4'd2, 32'h0);
    chk("R12", fault_vaddr, 32'h0);
    apply(32'hE100_0020, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R4", 4'd0, 32'hE100_0020);
    apply(32'hE100_0020, 1'b0, 1'b0, 1'b1, 1'b1, 2'd1, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R4", 4'd1, 32'h0);
    apply(32'hE400_0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R4", 4'd1, 32'h0);
  endtask

  task automatic t_xlate_off;
    apply(32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R5", 4'd0, 32'h1234_5678);
    apply(32'hD000_1000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 0, 0, 0, 32'h0, 32'h0);
    expect_rsp("R5", 4'd0, 32'h1000_1000);
  endtask

  task automatic t_asid;
    @(negedge clk);
    req_priv = 1'b1; cfg_single_vs = 1'b1; #1;
    chk("R6", {31'd0, tlb_cmp_asid}, 32'd0);
    req_priv = 1'b0; #1;
    chk("R6", {31'd0, tlb_cmp_asid}, 32'd1);
    req_priv = 1'b1; cfg_single_vs = 1'b0; #1;
    chk("R6", {31'd0, tlb_cmp_asid}, 32'd1);
  endtask

  task automatic t_miss_multi;
    apply(32'h0040_1000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 1, 1, 1, 32'h0, 32'hFFFF_F000);
    expect_rsp("R7", 4'd3, 32'h0);
    chk("R12", fault_vaddr, 32'h0040_1000);
    apply(32'h0050_0000, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1, 1, 1, 32'h0, 32'hFFFF_F000);
    expect_rsp("R7", 4'd4, 32'h0);
    apply(32'h0060_0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd3, 1, 1, 1, 32'h0, 32'hFFFF_F000);
    expect_rsp("R7", 4'd5, 32'h0);
    chk("R12", fault_vaddr, 32'h0060_0000);
  endtask

  task automatic t_protection;
    apply(32'h0070_0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 0, 1, 1, 32'h0300_0000, 32'hFFFF_0000);
    expect_rsp("R8", 4'd6, 32'h0);
    apply(32'h0070_0010, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 0, 0, 0, 32'h0300_0000, 32'hFFFF_0000);
    expect_rsp("R8", 4'd0, 32'h0300_0010);
    chk("R12", fault_vaddr, 32'h0070_0000);
    apply(32'h0070_0020, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 1, 0, 1, 32'h0300_0000, 32'hFFFF_0000);
    expect_rsp("R9", 4'd7, 32'h0);
    apply(32'h0070_0030, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 0, 1, 1, 32'h0300_0000, 32'hFFFF_0000);
    expect_rsp("R9", 4'd7, 32'h0);
    apply(32'h0070_0040, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1, 1, 0, 32'h0300_0000, 32'hFFFF_0000);
    expect_rsp("R10", 4'd8, 32'h0);
    chk("R12", fault_vaddr, 32'h0070_0040);
    apply(32'h0070_1234, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1, 1, 1, 32'h0300_0000, 32'hFFFF_0000);
    expect_rsp("R10", 4'd0, 32'h0300_1234);
  endtask

  task automatic t_compose;
    apply(32'h0040_0ABC, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1, 0, 0, 32'h0C12_3000, 32'hFFFF_F000);
    expect_rsp("R11", 4'd0, 32'h0C12_3ABC);
    apply(32'h0001_2345, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 0, 0, 0, 32'h1D00_0000, 32'hFFF0_0000);
    expect_rsp("R11", 4'd0, 32'hFD01_2345);
    apply(32'h0010_0000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 0, 0, 0, 32'h1C00_0000, 32'hFFF0_0000);
    expect_rsp("R11", 4'd0, 32'h1C00_0000);
    apply(32'hC000_2000, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 0, 0, 0, 32'h0200_0000, 32'hFFFF_F000);
    expect_rsp("R11", 4'd0, 32'h0200_0000);
    chk("R12", fault_vaddr, 32'h0070_0040);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_priv_pass();
    t_user_segments();
    t_xlate_off();
    t_asid();
    t_miss_multi();
    t_protection();
    t_compose();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule